// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block sits beside an existing asynchronous serial transmitter and decides what the request-to-send pin carries. In flow-control mode the pin simply follows the ordinary RTS level from the flow-control logic. In output-enable mode the pin becomes the direction control of a half-duplex RS-485 transceiver. The enable is raised the moment the transmitter signals the start of a character. It is released either at the end of the final stop bit or, when the turnaround hold is enabled, one full character time later.

The transmitter reports three single-cycle strobes: start of character, end of the last stop bit, and one tick per bit period. The character time used for the hold is a configured count of bit periods. That count is the start bit, the data bits, the optional parity bit and the stop bits. The same block can invert the serial TX line for inverted-line transceivers. Configuration inputs pass straight through while the block is idle. They are frozen once a transmission or hold is in progress, so the pin polarity can never change in the middle of a frame.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: With `cfg_oe_sel` = 0, `rts_pin` equals `rts_flow` in every cycle.
- R2: With `cfg_oe_sel` = 1, `rts_pin` equals `dir_busy` when `cfg_oe_pol` = 1 and equals the inverse of `dir_busy` when `cfg_oe_pol` = 0.
- R3: `dir_busy` is high in the same cycle as a `tx_start` strobe, before any registered state changes.
- R4: With `cfg_hold_en` = 0, `dir_busy` is high through the cycle of the `tx_done` strobe and low in the cycle after it, unless a new `tx_start` arrives.
- R5: With `cfg_hold_en` = 1, after `tx_done` the block stays busy while it counts `cfg_frame_len` `bit_tick` strobes. It goes low in the cycle after the last of those ticks. A frame length of 0 gives no hold.
- R6: A `tx_start` during the hold keeps `dir_busy` high with no low cycle and discards the remaining hold. The release is then timed from the next `tx_done`.
- R7: `txd_pin` equals `tx_raw` when `cfg_tx_inv` = 0 and its inverse when `cfg_tx_inv` = 1. With inversion the idle level is 0 and the start bit is 1.
- R8: While `rst_n` is low, `dir_busy` is 0, the enable sits at its inactive level for the configured polarity, and `txd_pin` follows the configured inversion.
- R9: Configuration inputs take effect only while no transmission and no hold are in progress. Changes made while busy are ignored until the block is idle again.
- R10: The frame length used for a hold is the one captured when the transmission began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Start-of-character strobe from the transmitter |
| tx_done | input | 1 | End-of-last-stop-bit strobe from the transmitter |
| bit_tick | input | 1 | One pulse per bit period |
| tx_raw | input | 1 | Serial line from the shift register, idle high |
| rts_flow | input | 1 | Normal flow-control RTS level |
| cfg_oe_sel | input | 1 | 0: pin carries RTS, 1: pin carries output enable |
| cfg_oe_pol | input | 1 | 0: enable active low, 1: enable active high |
| cfg_hold_en | input | 1 | Enables the one-character turnaround hold |
| cfg_tx_inv | input | 1 | Inverts the serial TX line |
| cfg_frame_len | input | 4 | Bit periods per character |
| rts_pin | output | 1 | Request-to-send or direction pin |
| txd_pin | output | 1 | Serial TX line after polarity |
| dir_busy | output | 1 | High while the direction enable is asserted |

## Verification
On every cycle, the assertions check the following: the hold loads the captured frame length; it counts down by one per tick; a start clears it; release without a hold comes one cycle after the stop-bit strobe; and the captured configuration holds still while busy. The bench scenarios are the only way to show the pin-level results. These are the polarity of the pin in each mode, the exact cycle of release after a hold, the absence of a low cycle when a character restarts the enable, and ignored configuration writes made in the middle of a frame.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  localparam int unsigned FLEN_W = 4;

  typedef struct packed {
    logic              oe_sel;
    logic              oe_pol;
    logic              hold_en;
    logic              tx_inv;
    logic [FLEN_W-1:0] frame_len;
  } dir_cfg_t;
endpackage

// File: rtl/rs485_cfg_capture.sv
module rs485_cfg_capture
  import rs485_dir_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     idle,
  input  dir_cfg_t cfg_live,
  output dir_cfg_t cfg_eff
);
  dir_cfg_t cfg_q, cfg_d;
  logic     cfg_en;

  // capture enable: only while nothing is in flight
  always_comb begin
    cfg_en = idle;
    cfg_d  = cfg_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // idle: live inputs act at once; busy: held copy
  always_comb cfg_eff = idle ? cfg_live : cfg_q;

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(cfg_q));
endmodule

// File: rtl/rs485_turnaround.sv
module rs485_turnaround
  import rs485_dir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              tx_done,
  input  logic              bit_tick,
  input  logic              hold_en,
  input  logic [FLEN_W-1:0] frame_len,
  output logic              busy,
  output logic              idle
);
  logic              sending_q, sending_d;
  logic [FLEN_W-1:0] hold_q, hold_d;
  logic              hold_live, load_hold;

  always_comb begin
    hold_live = (hold_q != '0);
    load_hold = tx_done && sending_q && hold_en && !tx_start;
    idle      = !sending_q && !hold_live;
    busy      = sending_q || hold_live || tx_start;

    sending_d = sending_q;
    if (tx_start)     sending_d = 1'b1;
    else if (tx_done) sending_d = 1'b0;

    hold_d = hold_q;
    if (tx_start)                    hold_d = '0;
    else if (load_hold)              hold_d = frame_len;
    else if (hold_live && bit_tick)  hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending_q <= 1'b0;
      hold_q    <= '0;
    end else begin
      sending_q <= sending_d;
      hold_q    <= hold_d;
    end
  end

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && sending_q && !hold_en && !tx_start) |=> (!sending_q && hold_q == '0));
  p_hold_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && sending_q && hold_en && !tx_start) |=> (hold_q == $past(frame_len)));
  p_hold_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0 && bit_tick && !tx_start) |=> (hold_q == $past(hold_q) - 1'b1));
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> (sending_q && hold_q == '0));
  p_hold_idle_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0) |-> !sending_q);
endmodule

// File: rtl/rs485_pin_drive.sv
module rs485_pin_drive
  import rs485_dir_pkg::*;
(
  input  dir_cfg_t cfg,
  input  logic     busy,
  input  logic     rts_flow,
  input  logic     tx_raw,
  output logic     rts_pin,
  output logic     txd_pin
);
  logic oe_level;

  always_comb begin
    oe_level = cfg.oe_pol ? busy : !busy;
    rts_pin  = cfg.oe_sel ? oe_level : rts_flow;
    txd_pin  = tx_raw ^ cfg.tx_inv;
  end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              tx_done,
  input  logic              bit_tick,
  input  logic              tx_raw,
  input  logic              rts_flow,
  input  logic              cfg_oe_sel,
  input  logic              cfg_oe_pol,
  input  logic              cfg_hold_en,
  input  logic              cfg_tx_inv,
  input  logic [FLEN_W-1:0] cfg_frame_len,
  output logic              rts_pin,
  output logic              txd_pin,
  output logic              dir_busy
);
  dir_cfg_t cfg_live, cfg_eff;
  logic     busy, idle;

  always_comb begin
    cfg_live.oe_sel    = cfg_oe_sel;
    cfg_live.oe_pol    = cfg_oe_pol;
    cfg_live.hold_en   = cfg_hold_en;
    cfg_live.tx_inv    = cfg_tx_inv;
    cfg_live.frame_len = cfg_frame_len;
  end

  rs485_cfg_capture u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle     (idle),
    .cfg_live (cfg_live),
    .cfg_eff  (cfg_eff)
  );

  rs485_turnaround u_turn (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_start  (tx_start),
    .tx_done   (tx_done),
    .bit_tick  (bit_tick),
    .hold_en   (cfg_eff.hold_en),
    .frame_len (cfg_eff.frame_len),
    .busy      (busy),
    .idle      (idle)
  );

  rs485_pin_drive u_pins (
    .cfg      (cfg_eff),
    .busy     (busy),
    .rts_flow (rts_flow),
    .tx_raw   (tx_raw),
    .rts_pin  (rts_pin),
    .txd_pin  (txd_pin)
  );

  always_comb dir_busy = busy;

  p_start_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && cfg_eff.oe_sel) |-> (rts_pin == cfg_eff.oe_pol));
endmodule

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic tx_start, tx_done, bit_tick, tx_raw, rts_flow;
  logic cfg_oe_sel, cfg_oe_pol, cfg_hold_en, cfg_tx_inv;
  logic [3:0] cfg_frame_len;
  logic rts_pin, txd_pin, dir_busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  // stimulus staged by scenarios, applied at negedge by step()
  logic s_rst_n = 1'b0, s_start = 0, s_done = 0, s_tick = 0, s_raw = 1, s_flow = 0;
  logic s_sel = 0, s_pol = 0, s_hold = 0, s_inv = 0;
  logic [3:0] s_len = 4'd10;

  // reference state
  logic m_send;
  logic [3:0] m_hold;
  logic m_sel, m_pol, m_hen, m_inv;
  logic [3:0] m_len;

  always #2 clk = ~clk;

  rs485_dir_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_done(tx_done),
    .bit_tick(bit_tick), .tx_raw(tx_raw), .rts_flow(rts_flow),
    .cfg_oe_sel(cfg_oe_sel), .cfg_oe_pol(cfg_oe_pol), .cfg_hold_en(cfg_hold_en),
    .cfg_tx_inv(cfg_tx_inv), .cfg_frame_len(cfg_frame_len),
    .rts_pin(rts_pin), .txd_pin(txd_pin), .dir_busy(dir_busy)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    logic idle, e_sel, e_pol, e_hen, e_inv, busy, e_rts;
    logic [3:0] e_len;
    @(negedge clk);
    rst_n = s_rst_n; tx_start = s_start; tx_done = s_done; bit_tick = s_tick;
    tx_raw = s_raw; rts_flow = s_flow; cfg_oe_sel = s_sel; cfg_oe_pol = s_pol;
    cfg_hold_en = s_hold; cfg_tx_inv = s_inv; cfg_frame_len = s_len;
    #1;
    if (!s_rst_n) begin
      m_send = 0; m_hold = 0; m_sel = 0; m_pol = 0; m_hen = 0; m_inv = 0; m_len = 0;
    end
    idle  = !m_send && (m_hold == 0);
    e_sel = idle ? s_sel  : m_sel;
    e_pol = idle ? s_pol  : m_pol;
    e_hen = idle ? s_hold : m_hen;
    e_inv = idle ? s_inv  : m_inv;
    e_len = idle ? s_len  : m_len;
    busy  = s_rst_n && (m_send || (m_hold != 0) || s_start);
    e_rts = e_sel ? (e_pol ? busy : !busy) : s_flow;
    chk(tag, "dir_busy", dir_busy, busy);
    chk(e_sel ? "R2" : "R1", {tag, " rts_pin"}, rts_pin, e_rts);
    chk("R7", {tag, " txd_pin"}, txd_pin, s_raw ^ e_inv);
    if (s_rst_n) begin
      if (idle) begin m_sel = s_sel; m_pol = s_pol; m_hen = s_hold; m_inv = s_inv; m_len = s_len; end
      if (s_start) m_hold = 0;
      else if (s_done && m_send && e_hen) m_hold = e_len;
      else if (m_hold != 0 && s_tick) m_hold = m_hold - 1;
      if (s_start) m_send = 1;
      else if (s_done) m_send = 0;
    end
  endtask

  task automatic idle_strobes();
    s_start = 0; s_done = 0; s_tick = 0;
  endtask

  // one character: start, n ticks, done
  task automatic frame(string tag, int nticks);
    idle_strobes(); s_start = 1; step(tag);
    s_start = 0;
    for (int i = 0; i < nticks; i++) begin
      s_tick = 1; s_raw = i[0]; step(tag); s_tick = 0; step(tag);
    end
    s_raw = 1; s_done = 1; s_tick = 1; step(tag); idle_strobes();
  endtask

  initial begin
    rst_n = 0; tx_start = 0; tx_done = 0; bit_tick = 0; tx_raw = 1; rts_flow = 0;
    cfg_oe_sel = 0; cfg_oe_pol = 0; cfg_hold_en = 0; cfg_tx_inv = 0; cfg_frame_len = 0;
    m_send = 0; m_hold = 0; m_sel = 0; m_pol = 0; m_hen = 0; m_inv = 0; m_len = 0;
    void'($urandom(32'h5EED_4850));

    // R8: reset state with OE mode, active low, inverted line
    s_rst_n = 0; s_sel = 1; s_pol = 0; s_inv = 1; s_raw = 1;
    repeat (3) step("R8");
    chk("R8", "rts inactive high in reset", rts_pin, 1'b1);
    chk("R8", "txd idle low in reset", txd_pin, 1'b0);
    s_rst_n = 1; s_inv = 0;
    step("R8");

    // R1: flow-control mode follows rts_flow through a frame
    s_sel = 0;
    for (int i = 0; i < 6; i++) begin s_flow = i[0]; step("R1"); end
    frame("R1", 3);

    // R3, R4: no hold, active high
    s_sel = 1; s_pol = 1; s_hold = 0; step("R4");
    s_start = 1; step("R3");
    chk("R3", "enable on start cycle", rts_pin, 1'b1);
    s_start = 0; step("R3");
    s_done = 1; step("R4");
    chk("R4", "still enabled in done cycle", dir_busy, 1'b1);
    s_done = 0; step("R4");
    chk("R4", "released after done", dir_busy, 1'b0);

    // R5, R10: hold of 10 ticks, frame length changed during frame
    s_hold = 1; s_len = 4'd10; step("R5");
    s_start = 1; step("R10"); s_start = 0;
    s_len = 4'd3; step("R10");
    s_done = 1; step("R5"); s_done = 0;
    for (int i = 0; i < 10; i++) begin
      step("R5");
      chk("R5", "held before tick", dir_busy, 1'b1);
      s_tick = 1; step("R10"); s_tick = 0;
    end
    step("R5");
    chk("R5", "released after last hold tick", dir_busy, 1'b0);

    // R5: frame length 0 gives no hold
    s_len = 4'd0; step("R5");
    frame("R5", 2); step("R5");
    chk("R5", "zero length no hold", dir_busy, 1'b0);

    // R6: restart inside hold, never low
    s_len = 4'd9; step("R6");
    frame("R6", 2);
    for (int i = 0; i < 4; i++) begin s_tick = 1; step("R6"); s_tick = 0; step("R6"); end
    s_start = 1; step("R6");
    chk("R6", "enable kept at restart", dir_busy, 1'b1);
    s_start = 0; step("R6");
    chk("R6", "enable kept after restart", dir_busy, 1'b1);
    s_done = 1; step("R6"); s_done = 0;
    for (int i = 0; i < 9; i++) begin s_tick = 1; step("R6"); s_tick = 0; end
    step("R6");
    chk("R6", "release timed from second done", dir_busy, 1'b0);

    // R9: polarity and inversion changes while busy are ignored
    s_hold = 0; s_pol = 1; s_inv = 0; step("R9");
    s_start = 1; step("R9"); s_start = 0;
    s_pol = 0; s_inv = 1; s_raw = 1; step("R9");
    chk("R9", "pol change ignored mid-frame", rts_pin, 1'b1);
    chk("R9", "inv change ignored mid-frame", txd_pin, 1'b1);
    s_done = 1; step("R9"); s_done = 0; step("R9");
    chk("R9", "new pol after idle", rts_pin, 1'b1);
    chk("R7", "new inversion after idle", txd_pin, 1'b0);

    // constrained random mix
    for (int c = 0; c < 4000; c++) begin
      s_start = ($urandom_range(0, 19) == 0);
      s_done  = m_send && ($urandom_range(0, 9) == 0);
      s_tick  = ($urandom_range(0, 2) == 0);
      s_raw   = $urandom_range(0, 1);
      s_flow  = $urandom_range(0, 1);
      if ($urandom_range(0, 29) == 0) begin
        s_sel = $urandom_range(0, 1); s_pol = $urandom_range(0, 1);
        s_hold = $urandom_range(0, 1); s_inv = $urandom_range(0, 1);
        s_len = 4'($urandom_range(0, 13));
      end
      step(s_hold ? "R5" : "R4");
    end
    if ($urandom_range(0, 1) == 0) s_rst_n = 0;
    idle_strobes(); step("R8"); s_rst_n = 0; step("R8");
    chk("R8", "busy clear in reset", dir_busy, 1'b0);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule